// File: doc/BRIEF.md
# Disk Controller Register Bank

This block is the processor-facing register set of a cartridge-disk controller sitting on a 16-bit I/O page. It recognises a small window of byte addresses, and within that window it holds six word registers: drive status, error, control/status, word count, bus address and disk address. Both full-word and single-byte writes are supported. Reads return the register contents, with two error-summary bits computed from the error register.

The block does not run commands itself. When the processor writes the control/status register with the start bit set while the controller is idle, the bank emits a one-cycle start pulse with the 3-bit function code to a separate command unit and marks itself busy. When that unit later reports completion, the bank goes idle again, merges the reported error bits, and raises an interrupt with a fixed vector if interrupts are enabled. Access strobes are level signals from the bus. The bank acts on their rising edges and returns read data to zero once the read strobe falls.

Top module: `dk_regbank`

## Requirements
- R1: `io_sel` is high in the cycle after the clock edge that samples `io_addr` inside 017400..017412 octal inclusive, and low otherwise (for example at 017376 or 017413).
- R2: Within the window, address bits 3:1 select a register: 0 drive status, 1 error, 2 control/status, 3 word count, 4 bus address, 5 disk address. A word write to word count or bus address reads back unchanged.
- R3: With `io_byte` high, address bit 0 low writes `io_wdata[7:0]` into bits 7:0 and bit 0 high writes `io_wdata[7:0]` into bits 15:8. The other byte keeps its value.
- R4: A write to the disk address register while DONE (control/status bit 7) is clear leaves that register unchanged.
- R5: A control/status write changes only the bits under mask 0006576 octal. DONE, the start bit (bit 0) and bits 9, 12..15 of the stored value are not set by the write. Reset leaves control/status at 0000200 octal.
- R6: A control/status write with bit 0 set while DONE is set gives a `go_pulse` lasting exactly one cycle, with `go_func` equal to written bits 3:1, and clears DONE. The same write while DONE is clear gives no pulse.
- R7: Writing IE (bit 6) as 0 drops `irq`. Writing IE as 1 while DONE is set and IE was clear raises `irq`. Writing IE as 1 when it was already set does not raise it.
- R8: A control/status read returns bit 15 set when the error register is nonzero and bit 14 set when any error bit under mask 0177740 octal is set.
- R9: `irq_vec` is 0220 octal while `irq` is high and 0 otherwise. A one-cycle `irq_ack` drops `irq`.
- R10: A drive status read returns `drive_id` in bits 15:13, with bits 11 and 8 set and all other bits clear.
- R11: After reset, control/status reads 0000200 octal, the error register reads 0, and `irq`, `go_pulse` and `io_rdata` are low.
- R12: `io_rdata` is loaded at the clock edge that sees the read strobe rise inside the window. It is zero in the cycle after the strobe is seen low, and an out-of-window read leaves it zero.
- R13: `cmd_done` sets DONE, ORs `cmd_err` into the error register, and raises `irq` if IE is set after that cycle's write. A start write in the same cycle as `cmd_done`, with DONE clear beforehand, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O byte address |
| io_wdata | input | 16 | Write data |
| io_rd | input | 1 | Read strobe (level) |
| io_wr | input | 1 | Write strobe (level) |
| io_byte | input | 1 | Byte write qualifier |
| io_rdata | output | 16 | Registered read data |
| io_sel | output | 1 | Address-in-window indication |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_vec | output | VEC_W | Interrupt vector |
| drive_id | input | 3 | Drive ID presented in drive status |
| go_pulse | output | 1 | One-cycle command start |
| go_func | output | 3 | Function code of the started command |
| cmd_done | input | 1 | Command completion from the command unit |
| cmd_err | input | 16 | Error bits reported with completion |

## Verification
Two events can land on the same clock edge: the command unit's completion and a processor write to control/status that carries the start bit together with IE. The bench drives both on the same clock edge while the controller is busy. The required outcome is no start pulse, DONE set, and an interrupt raised because the written IE is honoured by the completion. A second collision, where a start write that also sets IE lands while idle, must clear the interrupt rather than raise it.

// File: rtl/dk_pkg.sv
package dk_pkg;
  localparam int DW     = 16;
  localparam int SEL_W  = 3;
  localparam int FUNC_W = 3;
  localparam int ID_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    RS_DSTAT = 3'd0,
    RS_ERR   = 3'd1,
    RS_CTRL  = 3'd2,
    RS_WCNT  = 3'd3,
    RS_BADR  = 3'd4,
    RS_DADR  = 3'd5
  } reg_sel_e;

  localparam logic [DW-1:0] CTRL_WMASK = 16'o006576;
  localparam logic [DW-1:0] HARD_MASK  = 16'o177740;
  localparam logic [DW-1:0] CTRL_RST   = 16'o000200;
  localparam int DONE_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int GO_BIT   = 0;

  function automatic logic [DW-1:0] merge_bytes(
    input logic [DW-1:0] cur,
    input logic [DW-1:0] din,
    input logic          is_byte,
    input logic          hi
  );
    if (!is_byte)
      return din;
    else if (hi)
      return {din[7:0], cur[7:0]};
    else
      return {cur[15:8], din[7:0]};
  endfunction
endpackage

// File: rtl/dk_addr_dec.sv
module dk_addr_dec #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] FIRST = 13'o17400,
  parameter logic [ADDR_W-1:0] LAST  = 13'o17412
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic                    hit,
  output logic [dk_pkg::SEL_W-1:0] sel
);
  localparam int SEL_LSB = 1;

  always_comb begin
    hit = (addr >= FIRST) && (addr <= LAST);
    sel = addr[SEL_LSB +: dk_pkg::SEL_W];
  end
endmodule

// File: rtl/dk_edge.sv
module dk_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q;
  end
endmodule

// File: rtl/dk_regbank.sv
module dk_regbank
  import dk_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 13'o17400,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 13'o17412,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_VAL = 8'o220
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [15:0]       io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              io_byte,
  output logic [15:0]       io_rdata,
  output logic              io_sel,
  output logic              irq,
  input  logic              irq_ack,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic [2:0]        drive_id,
  output logic              go_pulse,
  output logic [2:0]        go_func,
  input  logic              cmd_done,
  input  logic [15:0]       cmd_err
);
  localparam int N_STB = 2;

  logic [DW-1:0] ctrl_q, err_q, wcnt_q, badr_q, dadr_q, rdata_q;
  logic          irq_q, go_q, sel_q;
  logic [FUNC_W-1:0] func_q;

  logic              hit;
  logic [SEL_W-1:0]  sel;
  logic [N_STB-1:0]  rise;

  dk_addr_dec #(.ADDR_W(ADDR_W), .FIRST(BASE_ADDR), .LAST(LAST_ADDR)) u_dec (
    .addr(io_addr), .hit(hit), .sel(sel)
  );

  dk_edge #(.N(N_STB)) u_edge (
    .clk(clk), .rst(rst), .lvl({io_wr, io_rd}), .rise(rise)
  );

  logic wr_fire, rd_fire, ctrl_wr, go_acc, ie_next, done_next;
  logic [DW-1:0] cur, merged, ctrl_base, rd_val;

  always_comb begin
    wr_fire = rise[1] & hit;
    rd_fire = rise[0] & hit;
    unique case (sel)
      RS_WCNT: cur = wcnt_q;
      RS_BADR: cur = badr_q;
      RS_DADR: cur = dadr_q;
      default: cur = ctrl_q;
    endcase
    merged    = merge_bytes(cur, io_wdata, io_byte, io_addr[0]);
    ctrl_wr   = wr_fire && (sel == RS_CTRL);
    go_acc    = ctrl_wr && ctrl_q[DONE_BIT] && merged[GO_BIT];
    ctrl_base = ctrl_wr ? ((ctrl_q & ~CTRL_WMASK) | (merged & CTRL_WMASK)) : ctrl_q;
    ie_next   = ctrl_base[IE_BIT];
    done_next = ctrl_q[DONE_BIT];
    if (go_acc)   done_next = 1'b0;
    if (cmd_done) done_next = 1'b1;
  end

  // Read value, with the error summary built at access time
  always_comb begin
    case (sel)
      RS_DSTAT: rd_val = {drive_id, 1'b0, 1'b1, 2'b00, 1'b1, 8'h00};
      RS_ERR:   rd_val = err_q;
      RS_CTRL:  rd_val = {(err_q != '0), ((err_q & HARD_MASK) != '0), ctrl_q[13:0]};
      RS_WCNT:  rd_val = wcnt_q;
      RS_BADR:  rd_val = badr_q;
      RS_DADR:  rd_val = dadr_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      err_q   <= '0;
      wcnt_q  <= '0;
      badr_q  <= '0;
      dadr_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
      go_q    <= 1'b0;
      func_q  <= '0;
      sel_q   <= 1'b0;
    end else begin
      sel_q  <= hit;
      ctrl_q <= {ctrl_base[15:DONE_BIT+1], done_next, ctrl_base[DONE_BIT-1:0]};
      go_q   <= go_acc;
      if (go_acc) func_q <= merged[3:1];

      if (wr_fire && sel == RS_WCNT) wcnt_q <= merged;
      if (wr_fire && sel == RS_BADR) badr_q <= merged;
      if (wr_fire && sel == RS_DADR && ctrl_q[DONE_BIT]) dadr_q <= merged;

      if (cmd_done) err_q <= err_q | cmd_err;

      if (rd_fire)     rdata_q <= rd_val;
      else if (!io_rd) rdata_q <= '0;

      // later statements take priority
      if (irq_ack) irq_q <= 1'b0;
      if (ctrl_wr) begin
        if (!merged[IE_BIT]) irq_q <= 1'b0;
        else if (ctrl_q[DONE_BIT] && !ctrl_q[IE_BIT]) irq_q <= 1'b1;
      end
      if (go_acc) irq_q <= 1'b0;
      if (cmd_done && ie_next) irq_q <= 1'b1;
    end
  end

  assign io_rdata = rdata_q;
  assign io_sel   = sel_q;
  assign irq      = irq_q;
  assign irq_vec  = irq_q ? VEC_VAL : '0;
  assign go_pulse = go_q;
  assign go_func  = func_q;

  // R6
  go_once_chk: assert property (@(posedge clk) disable iff (rst) go_q |=> !go_q);
  // R6
  go_gate_chk: assert property (@(posedge clk) disable iff (rst)
    go_q |-> ($past(ctrl_q[DONE_BIT]) && !ctrl_q[DONE_BIT]));
  // R4
  dadr_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && sel == RS_DADR && !ctrl_q[DONE_BIT]) |=> $stable(dadr_q));
  // R7
  irq_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> ctrl_q[DONE_BIT]);
  // R9
  ack_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !ctrl_wr && !cmd_done) |=> !irq_q);
  // R12
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> (rdata_q == '0));
endmodule

// File: tb/test_dk_regbank.sv
`timescale 1ns/1ps
module test_dk_regbank;
  localparam int AW = 13;
  localparam logic [AW-1:0] A_DS = 13'o17400, A_ER = 13'o17402, A_CS = 13'o17404,
                            A_WC = 13'o17406, A_BA = 13'o17410, A_DA = 13'o17412;

  logic clk = 0, rst = 1;
  logic [AW-1:0] io_addr = '0;
  logic [15:0] io_wdata = '0, cmd_err = '0;
  logic io_rd = 0, io_wr = 0, io_byte = 0, irq_ack = 0, cmd_done = 0;
  logic [2:0] drive_id = 3'd5;
  logic [15:0] io_rdata;
  logic io_sel, irq, go_pulse;
  logic [7:0] irq_vec;
  logic [2:0] go_func;

  int checks = 0, fails = 0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  dk_regbank i_dk_regbank (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_byte(io_byte), .io_rdata(io_rdata),
    .io_sel(io_sel), .irq(irq), .irq_ack(irq_ack), .irq_vec(irq_vec),
    .drive_id(drive_id), .go_pulse(go_pulse), .go_func(go_func),
    .cmd_done(cmd_done), .cmd_err(cmd_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %o expected %o", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_byte = b; io_wr = 1;
    @(negedge clk);
    io_wr = 0; io_byte = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    @(negedge clk);
    d = io_rdata;
    io_rd = 0;
    @(negedge clk);
    chk("R12 idle zero", io_rdata, 16'h0);
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic done_pulse(input logic [15:0] e);
    @(negedge clk); cmd_done = 1; cmd_err = e;
    @(negedge clk); cmd_done = 0; cmd_err = 0;
  endtask

  task automatic t_reset();
    chk("R11 irq", {15'd0, irq}, 16'h0);
    chk("R11 go", {15'd0, go_pulse}, 16'h0);
    chk("R11 rdata", io_rdata, 16'h0);
    rd(A_CS, rv); chk("R11 ctrl", rv, 16'o000200);
    rd(A_ER, rv); chk("R11 err", rv, 16'h0);
  endtask

  task automatic t_decode();
    @(negedge clk); io_addr = 13'o17400; @(negedge clk); chk("R1 low edge", {15'd0, io_sel}, 16'd1);
    io_addr = 13'o17412; @(negedge clk); chk("R1 high edge", {15'd0, io_sel}, 16'd1);
    io_addr = 13'o17413; @(negedge clk); chk("R1 above", {15'd0, io_sel}, 16'd0);
    io_addr = 13'o17376; @(negedge clk); chk("R1 below", {15'd0, io_sel}, 16'd0);
    rd(13'o17414, rv); chk("R12 out of window", rv, 16'h0);
  endtask

  task automatic t_regs();
    rd(A_DS, rv); chk("R10 drive status", rv, 16'hA900);
    wr(A_WC, 16'h1234, 0); rd(A_WC, rv); chk("R2 wcnt", rv, 16'h1234);
    wr(A_BA, 16'h5555, 0); rd(A_BA, rv); chk("R2 badr", rv, 16'h5555);
    wr(A_WC, 16'h00AB, 1); rd(A_WC, rv); chk("R3 low byte", rv, 16'h12AB);
    wr(A_WC | 13'd1, 16'h00CD, 1); rd(A_WC, rv); chk("R3 high byte", rv, 16'hCDAB);
  endtask

  task automatic t_mask();
    wr(A_CS, 16'hFFFE, 0);
    chk("R7 raise on IE", {15'd0, irq}, 16'd1);
    chk("R9 vector", {8'd0, irq_vec}, 16'o220);
    rd(A_CS, rv); chk("R5 mask", rv, 16'h0DFE);
    ack();
    chk("R9 ack", {15'd0, irq}, 16'd0);
    chk("R9 vector zero", {8'd0, irq_vec}, 16'd0);
    wr(A_CS, 16'h0000, 0); rd(A_CS, rv); chk("R5 clear", rv, 16'o000200);
  endtask

  task automatic t_ie();
    wr(A_CS, 16'h0040, 0); chk("R7 raise", {15'd0, irq}, 16'd1);
    wr(A_CS, 16'h0000, 0); chk("R7 IE off", {15'd0, irq}, 16'd0);
    wr(A_CS, 16'h0040, 0); ack();
    wr(A_CS, 16'h0040, 0); chk("R7 no re-raise", {15'd0, irq}, 16'd0);
    wr(A_CS, 16'h0000, 0);
  endtask

  task automatic t_go();
    wr(A_DA, 16'h1111, 0); rd(A_DA, rv); chk("R2 dadr", rv, 16'h1111);
    wr(A_CS, 16'h0005, 0);
    chk("R6 pulse", {15'd0, go_pulse}, 16'd1);
    chk("R6 func", {13'd0, go_func}, 16'd2);
    @(negedge clk); chk("R6 one cycle", {15'd0, go_pulse}, 16'd0);
    rd(A_CS, rv); chk("R6 busy", rv, 16'h0004);
    wr(A_DA, 16'h0777, 0); rd(A_DA, rv); chk("R4 locked", rv, 16'h1111);
    wr(A_CS, 16'h0007, 0); chk("R6 no pulse busy", {15'd0, go_pulse}, 16'd0);
  endtask

  task automatic t_done();
    done_pulse(16'h0001);
    chk("R13 no irq IE off", {15'd0, irq}, 16'd0);
    rd(A_CS, rv); chk("R8 soft summary", rv, 16'h8086);
    rd(A_ER, rv); chk("R13 err", rv, 16'h0001);
    done_pulse(16'h0020);
    rd(A_CS, rv); chk("R8 hard summary", rv, 16'hC086);
    rd(A_ER, rv); chk("R13 err or", rv, 16'h0021);
  endtask

  task automatic t_collide();
    wr(A_CS, 16'h0045, 0);
    chk("R6 pulse w/ IE", {15'd0, go_pulse}, 16'd1);
    chk("R7 go clears irq", {15'd0, irq}, 16'd0);
    @(negedge clk);
    io_addr = A_CS; io_wdata = 16'h0045; io_wr = 1; cmd_done = 1; cmd_err = 0;
    @(negedge clk);
    io_wr = 0; cmd_done = 0;
    chk("R13 no go on collide", {15'd0, go_pulse}, 16'd0);
    chk("R13 irq on collide", {15'd0, irq}, 16'd1);
    rd(A_CS, rv); chk("R13 ctrl after", rv, 16'hC0C4);
    ack(); chk("R9 ack final", {15'd0, irq}, 16'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_regs();
    t_mask();
    t_ie();
    t_go();
    t_done();
    t_collide();
    summary();
    $finish;
  end
endmodule